// File: doc/BRIEF.md
# Ternary Lookup Table with Lowest-Index Priority

This block is a table of entries, each holding a ternary pattern in which every bit position is zero, one or "any". Software-side logic loads and inspects entries by index, much as it would with a small addressed RAM. A lookup key is compared against every valid entry at once. The block returns a per-entry hit vector, a single hit flag, and the index of the winning entry. The winner is the lowest-numbered entry among those that agree.

Each bit position of an entry is stored as a two-bit code, and one of the four codes is forbidden. A load that carries the forbidden code anywhere is refused and reported. Each entry also carries a valid flag. Cleared entries never take part in a lookup, and reset clears every flag. A lookup registers the key on one clock edge. The results are then presented for the whole of the following cycle.

Top module: `tcam_lookup`

## Requirements
- R1: A load with `wr_en` high and no forbidden code stores `wr_cells` and `wr_valid` into entry `wr_addr`. A fetch with `rd_en` high returns that entry's codes on `rd_cells`, and its flag on `rd_entry_valid`, in the cycle after the edge that samples the request, with `rd_valid` high for that one cycle.
- R2: Bit position k of an entry sits in bits [2k+1:2k] of `wr_cells`/`rd_cells`. Code 2'b01 means zero, 2'b10 means one, 2'b00 means any, and 2'b11 is forbidden.
- R3: A load that contains 2'b11 in any position leaves the addressed entry's codes and flag unchanged. In that case `wr_err` is high for exactly the cycle after the sampling edge.
- R4: When `srch_en` is sampled high at an edge, `res_valid`, `hit`, `match_addr` and `match_vec` give that key's result during the next cycle. Entry i sets `match_vec[i]` only if it is valid and every bit position agrees with the key.
- R5: A position holding code "any" agrees with both key values.
- R6: When several entries agree, `match_addr` is the lowest index among them.
- R7: When no entry agrees, or no lookup result is being presented, `hit` is 0, `match_addr` is 0 and `match_vec` is 0.
- R8: An entry loaded with `wr_valid` = 0 never agrees with any key.
- R9: Reset clears all valid flags and drives `hit`, `res_valid`, `rd_valid` and `wr_err` low.
- R10: A lookup sampled on the same edge as a load sees the table as it is after that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load request |
| wr_addr | input | ADDR_W | Entry index to load |
| wr_cells | input | 2*WIDTH | Ternary codes to store |
| wr_valid | input | 1 | Valid flag to store |
| wr_err | output | 1 | Previous load was refused |
| rd_en | input | 1 | Fetch request |
| rd_addr | input | ADDR_W | Entry index to fetch |
| rd_cells | output | 2*WIDTH | Fetched codes |
| rd_entry_valid | output | 1 | Fetched valid flag |
| rd_valid | output | 1 | Fetch data present |
| srch_en | input | 1 | Lookup request |
| srch_key | input | WIDTH | Lookup key |
| res_valid | output | 1 | Lookup result present |
| hit | output | 1 | At least one entry agrees |
| match_addr | output | ADDR_W | Lowest agreeing index |
| match_vec | output | ENTRIES | Per-entry agreement |

## Verification
A corrupted entry code or valid flag shows at the ports in two ways. It appears on the next fetch of that entry. It also appears one cycle after any lookup that exercises the damaged position, as a wrong bit in `match_vec`. A fault in the priority logic shows as a `match_addr` that points to an agreeing entry other than the lowest one. It is visible in the same result cycle whenever two or more entries agree. A refused load that nonetheless alters storage is exposed by the fetch that directly follows it.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    CELL_ANY  = 2'b00,
    CELL_ZERO = 2'b01,
    CELL_ONE  = 2'b10,
    CELL_BAD  = 2'b11
  } cell_e;

  // Does one stored code accept one key bit?
  function automatic logic cell_accepts(input logic [1:0] code, input logic kbit);
    logic ok;
    case (code)
      CELL_ANY:  ok = 1'b1;
      CELL_ZERO: ok = ~kbit;
      CELL_ONE:  ok = kbit;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tcam_row.sv
module tcam_row
  import tcam_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               load_valid,
  input  logic [2*WIDTH-1:0] load_cells,
  input  logic [WIDTH-1:0]   key,
  output logic               agree,
  output logic [2*WIDTH-1:0] cells_q,
  output logic               valid_q
);

  logic [2*WIDTH-1:0] cells_d;
  logic               valid_d;
  logic [WIDTH-1:0]   bit_ok;

  always_comb begin
    cells_d = cells_q;
    valid_d = valid_q;
    if (load) begin
      cells_d = load_cells;
      valid_d = load_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '0;
      valid_q <= 1'b0;
    end else begin
      cells_q <= cells_d;
      valid_q <= valid_d;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign bit_ok[b] = cell_accepts(cells_q[2*b+1:2*b], key[b]);
  end

  assign agree = valid_q & (&bit_ok);

  // R3
  no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cells_q == $past(load_cells)));

  // R8
  invalid_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_valid) |=> !agree);

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int ENTRIES = 16,
  localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [ADDR_W-1:0]  idx
);

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = ADDR_W'(i);
    end
  end

  assign any = |req;

  // R6
  win_is_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]);

  // R6
  win_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & ((ENTRIES'(1) << idx) - ENTRIES'(1))) == '0));

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8,
  localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CELL_W = 2 * WIDTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CELL_W-1:0]  wr_cells,
  input  logic               wr_valid,
  output logic               wr_err,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CELL_W-1:0]  rd_cells,
  output logic               rd_entry_valid,
  output logic               rd_valid,
  input  logic               srch_en,
  input  logic [WIDTH-1:0]   srch_key,
  output logic               res_valid,
  output logic               hit,
  output logic [ADDR_W-1:0]  match_addr,
  output logic [ENTRIES-1:0] match_vec
);

  logic [WIDTH-1:0]  bad_pos;
  logic              wr_bad;
  logic              wr_ok;
  logic [ENTRIES-1:0] row_load;
  logic [ENTRIES-1:0] row_agree;
  logic [CELL_W-1:0] row_cells [ENTRIES];
  logic [ENTRIES-1:0] row_valid;

  logic [WIDTH-1:0]  key_q, key_d;
  logic              srch_q, srch_d;
  logic [CELL_W-1:0] rd_cells_d;
  logic              rd_ev_d, rd_valid_d, wr_err_d;
  logic              pe_any;
  logic [ADDR_W-1:0] pe_idx;

  // forbidden-code screen on the incoming load
  for (genvar b = 0; b < WIDTH; b++) begin : g_screen
    assign bad_pos[b] = (wr_cells[2*b+1:2*b] == CELL_BAD);
  end
  assign wr_bad = |bad_pos;
  assign wr_ok  = wr_en & ~wr_bad;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    assign row_load[e] = wr_ok & (wr_addr == ADDR_W'(e));
    tcam_row #(.WIDTH(WIDTH)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (row_load[e]),
      .load_valid (wr_valid),
      .load_cells (wr_cells),
      .key        (key_q),
      .agree      (row_agree[e]),
      .cells_q    (row_cells[e]),
      .valid_q    (row_valid[e])
    );
  end

  // next-state for key, fetch and status registers
  always_comb begin
    key_d      = key_q;
    srch_d     = srch_en;
    if (srch_en) key_d = srch_key;
    rd_valid_d = rd_en;
    rd_cells_d = rd_cells;
    rd_ev_d    = rd_entry_valid;
    if (rd_en) begin
      rd_cells_d = '0;
      rd_ev_d    = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (rd_addr == ADDR_W'(e)) begin
          rd_cells_d = row_cells[e];
          rd_ev_d    = row_valid[e];
        end
      end
    end
    wr_err_d = wr_en & wr_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q          <= '0;
      srch_q         <= 1'b0;
      rd_cells       <= '0;
      rd_entry_valid <= 1'b0;
      rd_valid       <= 1'b0;
      wr_err         <= 1'b0;
    end else begin
      key_q          <= key_d;
      srch_q         <= srch_d;
      rd_cells       <= rd_cells_d;
      rd_entry_valid <= rd_ev_d;
      rd_valid       <= rd_valid_d;
      wr_err         <= wr_err_d;
    end
  end

  tcam_prio #(.ENTRIES(ENTRIES)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (row_agree),
    .any   (pe_any),
    .idx   (pe_idx)
  );

  assign res_valid  = srch_q;
  assign hit        = srch_q & pe_any;
  assign match_addr = hit ? pe_idx : '0;
  assign match_vec  = srch_q ? row_agree : '0;

  // R4
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> res_valid);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (match_addr == '0 && match_vec == '0));

  // R3
  err_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));

  // R1
  fetch_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

endmodule

// File: tb/tcam_lookup_test.sv
module tcam_lookup_test;

  localparam int N  = 16;
  localparam int W  = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_valid = 1'b0, rd_en = 1'b0, srch_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [2*W-1:0] wr_cells = '0;
  logic [W-1:0] srch_key = '0;
  logic wr_err, rd_entry_valid, rd_valid, res_valid, hit;
  logic [2*W-1:0] rd_cells;
  logic [AW-1:0] match_addr;
  logic [N-1:0] match_vec;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tcam_lookup #(.ENTRIES(N), .WIDTH(W)) uut (.*);

  // key, expected hit, expected index, expected vector
  localparam logic [W+1+AW+N-1:0] VEC [4] = '{
    {8'hA5, 1'b1, 4'd0,  16'h8003},
    {8'h13, 1'b1, 4'd3,  16'h8008},
    {8'hA3, 1'b1, 4'd0,  16'h8009},
    {8'h55, 1'b1, 4'd15, 16'h8000}
  };

  function automatic logic [2*W-1:0] enc(input logic [W-1:0] val, input logic [W-1:0] care);
    logic [2*W-1:0] c;
    for (int k = 0; k < W; k++)
      c[2*k +: 2] = !care[k] ? 2'b00 : (val[k] ? 2'b10 : 2'b01);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [2*W-1:0] c, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_cells = c; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic look(input logic [W-1:0] k);
    @(negedge clk);
    srch_en = 1'b1; srch_key = k;
    @(negedge clk);
    srch_en = 1'b0;
  endtask

  task automatic check_result(input string req, input logic h, input logic [AW-1:0] a,
                              input logic [N-1:0] v);
    chk({req, " res_valid"}, 32'(res_valid), 32'd1);
    chk({req, " hit"}, 32'(hit), 32'(h));
    chk({req, " match_addr"}, 32'(match_addr), 32'(a));
    chk({req, " match_vec"}, 32'(match_vec), 32'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 hit", 32'(hit), 32'd0);
    chk("R9 res_valid", 32'(res_valid), 32'd0);
    chk("R9 rd_valid", 32'(rd_valid), 32'd0);
    chk("R9 wr_err", 32'(wr_err), 32'd0);
    rst_n = 1'b1;
    look(8'hA5);
    check_result("R9 empty table", 1'b0, '0, '0);

    load(4'd0, enc(8'hA0, 8'hF0), 1'b1);
    load(4'd1, enc(8'hA5, 8'hFF), 1'b1);
    load(4'd3, enc(8'h03, 8'h0F), 1'b1);
    load(4'd15, enc(8'h00, 8'h00), 1'b1);

    // R4 R5 R6 table walk
    for (int i = 0; i < 4; i++) begin
      look(VEC[i][W+AW+N:AW+N+1]);
      check_result("R4/R5/R6 vector", VEC[i][AW+N], VEC[i][AW+N-1:N], VEC[i][N-1:0]);
    end

    // R1 R2 fetch returns codes and flag
    fetch(4'd1);
    chk("R1 rd_valid", 32'(rd_valid), 32'd1);
    chk("R2 rd_cells", 32'(rd_cells), 32'(enc(8'hA5, 8'hFF)));
    chk("R1 rd_entry_valid", 32'(rd_entry_valid), 32'd1);

    // R3 forbidden code refused
    load(4'd3, 16'h000C, 1'b1);
    chk("R3 wr_err", 32'(wr_err), 32'd1);
    @(negedge clk);
    chk("R3 wr_err one cycle", 32'(wr_err), 32'd0);
    fetch(4'd3);
    chk("R3 cells kept", 32'(rd_cells), 32'(enc(8'h03, 8'h0F)));
    chk("R3 flag kept", 32'(rd_entry_valid), 32'd1);
    look(8'h13);
    check_result("R3 entry still live", 1'b1, 4'd3, 16'h8008);

    // R8 R7 clear catch-all entry
    load(4'd15, enc(8'h00, 8'h00), 1'b0);
    look(8'h55);
    check_result("R8/R7 no agree", 1'b0, '0, '0);
    @(negedge clk);
    chk("R7 idle hit", 32'(hit), 32'd0);
    chk("R7 idle vec", 32'(match_vec), 32'd0);

    // R10 load and lookup on the same edge
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd5; wr_cells = enc(8'h77, 8'hFF); wr_valid = 1'b1;
    srch_en = 1'b1; srch_key = 8'h77;
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    check_result("R10 same edge", 1'b1, 4'd5, 16'h0020);

    // R9 reset clears flags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(8'hA5);
    check_result("R9 after reset", 1'b0, '0, '0);
    fetch(4'd1);
    chk("R9 flag cleared", 32'(rd_entry_valid), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule